// File: doc/BRIEF.md
# Single-Accumulator Datapath with Summing Sequencer

This block is a small arithmetic datapath built around one accumulator register. A 9-bit control word drives it every cycle. One field picks what the accumulator is offered: the external operand, or the result of an ALU followed by a one-place shifter. Another field says whether the accumulator holds, loads or clears. A three-bit field selects the ALU operation, which combines the accumulator with the external operand. A two-bit field steers the shifter. The lowest bit gates the accumulator value onto the output port.

A sequencer sits in front of the datapath and issues the control words. While it is idle, a control word supplied at the ports can steer the datapath directly, one operation per cycle. A start pulse launches a summing run instead. The sequencer clears the accumulator, then adds one sample for each valid strobe until it has taken `N_SAMPLES` of them. It then shows the total on the output for a single cycle and flags completion. The sum wraps modulo 2^`WIDTH`.

Top module: `acc_sum_top`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `data_out` is zero and `out_en`, `done` and `busy` are low. The accumulator starts at zero.
- R2: The control word is laid out as {bit 8 source select, bits 7:6 accumulator op, bits 5:3 ALU op, bits 2:1 shift op, bit 0 output enable}. For the accumulator op, 01 loads, 10 clears to zero, and 00 and 11 both hold. Each op takes effect at the next rising clock edge.
- R3: When bit 8 is 1, a load takes `data_in`. When bit 8 is 0, a load takes the shifter result.
- R4: ALU ops with bit 5 = 0 are arithmetic on A = accumulator and B = `data_in`, modulo 2^WIDTH: 000 gives A, 001 gives A+B, 010 gives A-B, 011 gives A+1.
- R5: ALU ops with bit 5 = 1 are logic: 100 gives A AND B, 101 gives A OR B, 110 gives A XOR B, 111 gives NOT A.
- R6: Shift op 00 passes the ALU result through, 01 shifts it left by one with a 0 fill, 10 shifts it right by one with a 0 fill, and 11 passes it through.
- R7: When bit 0 of the active control word is 1, `data_out` equals the accumulator and `out_en` is 1, in the same cycle. Otherwise `data_out` is zero and `out_en` is 0.
- R8: A `start` pulse while idle clears the accumulator in the following cycle. After that, every cycle with `sample_valid` high adds `data_in` to the accumulator, until `N_SAMPLES` samples have been added. The total wraps modulo 2^WIDTH.
- R9: In the cycle after the edge that takes the last sample, `done` and `out_en` are high and `data_out` shows the sum. One cycle later `done` is low and the block is idle again.
- R10: While `busy` is high, the block ignores `start`, `ext_ctrl_en` and `ext_ctrl`. Cycles with `sample_valid` low leave the sum unchanged.
- R11: While idle with `ext_ctrl_en` high, `ext_ctrl` is the active control word. While idle with `ext_ctrl_en` low, the accumulator holds and `out_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launches a summing run when idle |
| sample_valid | input | 1 | Marks `data_in` as a sample during a run |
| data_in | input | WIDTH | External operand and sample data |
| ext_ctrl_en | input | 1 | Makes `ext_ctrl` the active word while idle |
| ext_ctrl | input | 9 | Direct control word |
| data_out | output | WIDTH | Gated accumulator value |
| out_en | output | 1 | Output enable bit of the active word |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle completion flag |

## Verification
The bench builds the block with its defaults: WIDTH = 8 and N_SAMPLES = 100. With one hundred samples of up to 255 each, the total passes 256 many times, so the modulo wrap of the sum is exercised for certain. The full-length run also covers the sample counter all the way to its terminal value. The 8-bit width lets the bench reach the edges of each ALU and shift op with a few chosen operands, such as an MSB-set value for the left shift and 0 − 1 for the subtract wrap.

// File: rtl/acc_dp_pkg.sv
package acc_dp_pkg;

  localparam int CW_BITS = 9;

  typedef enum logic [1:0] {
    ACC_HOLD  = 2'b00,
    ACC_LOAD  = 2'b01,
    ACC_CLEAR = 2'b10,
    ACC_KEEP  = 2'b11
  } acc_op_e;

  typedef enum logic [1:0] {
    SH_PASS  = 2'b00,
    SH_LEFT  = 2'b01,
    SH_RIGHT = 2'b10,
    SH_THRU  = 2'b11
  } shift_op_e;

  // bit 8 | 7:6 | 5 | 4:3 | 2:1 | 0
  typedef struct packed {
    logic      in_sel;
    acc_op_e   acc_op;
    logic      alu_mode;
    logic [1:0] alu_sel;
    shift_op_e shift_op;
    logic      out_en;
  } ctrl_word_t;

  typedef enum logic [1:0] {
    S_IDLE  = 2'b00,
    S_CLEAR = 2'b01,
    S_RUN   = 2'b10,
    S_DONE  = 2'b11
  } seq_state_e;

endpackage

// File: rtl/acc_alu.sv
module acc_alu #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             mode_i,
  input  logic [1:0]       sel_i,
  output logic [WIDTH-1:0] y_o
);

  always_comb begin
    unique case ({mode_i, sel_i})
      3'b000:  y_o = a_i;
      3'b001:  y_o = a_i + b_i;
      3'b010:  y_o = a_i - b_i;
      3'b011:  y_o = a_i + WIDTH'(1);
      3'b100:  y_o = a_i & b_i;
      3'b101:  y_o = a_i | b_i;
      3'b110:  y_o = a_i ^ b_i;
      default: y_o = ~a_i;
    endcase
  end

endmodule

// File: rtl/acc_shifter.sv
module acc_shifter
  import acc_dp_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] din_i,
  input  shift_op_e        op_i,
  output logic [WIDTH-1:0] dout_o
);

  always_comb begin
    unique case (op_i)
      SH_LEFT:  dout_o = {din_i[WIDTH-2:0], 1'b0};
      SH_RIGHT: dout_o = {1'b0, din_i[WIDTH-1:1]};
      default:  dout_o = din_i;
    endcase
  end

endmodule

// File: rtl/acc_datapath.sv
module acc_datapath
  import acc_dp_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctrl_word_t       cw_i,
  input  logic [WIDTH-1:0] din_i,
  output logic [WIDTH-1:0] dout_o,
  output logic             oe_o
);

  logic [WIDTH-1:0] acc_q, acc_d;
  logic [WIDTH-1:0] alu_y, sh_y, src_y;

  acc_alu #(.WIDTH(WIDTH)) u_alu (
    .a_i   (acc_q),
    .b_i   (din_i),
    .mode_i(cw_i.alu_mode),
    .sel_i (cw_i.alu_sel),
    .y_o   (alu_y)
  );

  acc_shifter #(.WIDTH(WIDTH)) u_shift (
    .din_i (alu_y),
    .op_i  (cw_i.shift_op),
    .dout_o(sh_y)
  );

  assign src_y = cw_i.in_sel ? din_i : sh_y;

  always_comb begin
    acc_d = acc_q;
    unique case (cw_i.acc_op)
      ACC_LOAD:  acc_d = src_y;
      ACC_CLEAR: acc_d = '0;
      default:   acc_d = acc_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assign dout_o = cw_i.out_en ? acc_q : '0;
  assign oe_o   = cw_i.out_en;

  p_clear_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cw_i.acc_op == ACC_CLEAR) |=> (acc_q == '0));

  p_hold_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((cw_i.acc_op == ACC_HOLD) || (cw_i.acc_op == ACC_KEEP)) |=> $stable(acc_q));

  p_load_ext_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((cw_i.acc_op == ACC_LOAD) && cw_i.in_sel) |=> (acc_q == $past(din_i)));

endmodule

// File: rtl/acc_sequencer.sv
module acc_sequencer
  import acc_dp_pkg::*;
#(
  parameter int N_SAMPLES = 100
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               valid_i,
  input  logic               ext_en_i,
  input  logic [CW_BITS-1:0] ext_cw_i,
  output ctrl_word_t         cw_o,
  output logic               busy_o,
  output logic               done_o
);

  localparam int CNT_W = (N_SAMPLES > 1) ? $clog2(N_SAMPLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(N_SAMPLES - 1);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cw_o    = '0;
    unique case (state_q)
      S_IDLE: begin
        if (ext_en_i) cw_o = ctrl_word_t'(ext_cw_i);
        if (start_i) begin
          state_d = S_CLEAR;
          cnt_d   = '0;
        end
      end
      S_CLEAR: begin
        cw_o.acc_op = ACC_CLEAR;
        state_d     = S_RUN;
      end
      S_RUN: begin
        cw_o.alu_sel = 2'b01;
        if (valid_i) begin
          cw_o.acc_op = ACC_LOAD;
          if (cnt_q == LAST) begin
            cnt_d   = '0;
            state_d = S_DONE;
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
      end
      default: begin
        cw_o.out_en = 1'b1;
        state_d     = S_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign busy_o = (state_q != S_IDLE);
  assign done_o = (state_q == S_DONE);

  p_start_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == S_IDLE) && start_i) |=> (cw_o.acc_op == ACC_CLEAR));

  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_RUN) |-> (cnt_q <= LAST));

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_done_oe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> cw_o.out_en);

endmodule

// File: rtl/acc_sum_top.sv
module acc_sum_top
  import acc_dp_pkg::*;
#(
  parameter int WIDTH     = 8,
  parameter int N_SAMPLES = 100
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               sample_valid,
  input  logic [WIDTH-1:0]   data_in,
  input  logic               ext_ctrl_en,
  input  logic [CW_BITS-1:0] ext_ctrl,
  output logic [WIDTH-1:0]   data_out,
  output logic               out_en,
  output logic               busy,
  output logic               done
);

  logic [1:0] rst_sync_q;
  logic       rst_n_int;
  ctrl_word_t cw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  acc_sequencer #(.N_SAMPLES(N_SAMPLES)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .start_i (start),
    .valid_i (sample_valid),
    .ext_en_i(ext_ctrl_en),
    .ext_cw_i(ext_ctrl),
    .cw_o    (cw),
    .busy_o  (busy),
    .done_o  (done)
  );

  acc_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk   (clk),
    .rst_n (rst_n_int),
    .cw_i  (cw),
    .din_i (data_in),
    .dout_o(data_out),
    .oe_o  (out_en)
  );

  p_gate_low_r7: assert property (@(posedge clk) disable iff (!rst_n_int)
    !out_en |-> (data_out == '0));

  p_done_visible_r9: assert property (@(posedge clk) disable iff (!rst_n_int)
    done |-> out_en);

endmodule

// File: tb/acc_sum_top_bench.sv
module acc_sum_top_bench;

  localparam int W = 8;
  localparam int N = 100;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         start, sample_valid, ext_ctrl_en;
  logic [W-1:0] data_in;
  logic [8:0]   ext_ctrl;
  logic [W-1:0] data_out;
  logic         out_en, busy, done;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  acc_sum_top #(.WIDTH(W), .N_SAMPLES(N)) u_acc_sum_top (
    .clk(clk), .rst_n(rst_n), .start(start), .sample_valid(sample_valid),
    .data_in(data_in), .ext_ctrl_en(ext_ctrl_en), .ext_ctrl(ext_ctrl),
    .data_out(data_out), .out_en(out_en), .busy(busy), .done(done)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [8:0] cw(logic sel, logic [1:0] acc, logic [2:0] alu,
                                    logic [1:0] sh, logic oe);
    return {sel, acc, alu, sh, oe};
  endfunction

  function automatic logic [W-1:0] model(logic [W-1:0] a, logic [W-1:0] b,
                                         logic [2:0] alu, logic [1:0] sh);
    logic [W-1:0] y;
    case (alu)
      3'd0: y = a;
      3'd1: y = a + b;
      3'd2: y = a - b;
      3'd3: y = a + 1'b1;
      3'd4: y = a & b;
      3'd5: y = a | b;
      3'd6: y = a ^ b;
      default: y = ~a;
    endcase
    if (sh == 2'b01) y = y << 1;
    else if (sh == 2'b10) y = y >> 1;
    return y;
  endfunction

  task automatic read_acc(string req, logic [W-1:0] exp);
    ext_ctrl_en = 1'b1;
    ext_ctrl = cw(1'b0, 2'b00, 3'd0, 2'b00, 1'b1);
    #1;
    check(req, data_out, exp);
    check(req, out_en, 1'b1);
  endtask

  task automatic load_ext(logic [W-1:0] v);
    ext_ctrl_en = 1'b1;
    ext_ctrl = cw(1'b1, 2'b01, 3'd0, 2'b00, 1'b0);
    data_in = v;
    step();
  endtask

  task automatic t_reset();
    rst_n = 1'b0; start = 0; sample_valid = 0; ext_ctrl_en = 0;
    ext_ctrl = '0; data_in = '0;
    repeat (3) step();
    check("R1 data_out in reset", data_out, 0);
    check("R1 out_en in reset", out_en, 0);
    check("R1 done in reset", done, 0);
    rst_n = 1'b1;
    step();
    check("R1 busy after reset", busy, 0);
    check("R1 done after reset", done, 0);
    repeat (2) step();
    read_acc("R1 accumulator zero", '0);
  endtask

  task automatic t_load_select();
    load_ext(8'h5A);
    read_acc("R3 load external", 8'h5A);
    // R3: sel=0 loads shifter result of A+B
    ext_ctrl = cw(1'b0, 2'b01, 3'd1, 2'b00, 1'b0);
    data_in = 8'h10;
    step();
    read_acc("R3 load result", 8'h6A);
  endtask

  task automatic t_alu_ops();
    logic [W-1:0] av [4] = '{8'h00, 8'hC3, 8'h7F, 8'hFF};
    logic [W-1:0] bv [4] = '{8'h01, 8'h5A, 8'h81, 8'h0F};
    for (int op = 0; op < 8; op++) begin
      for (int k = 0; k < 4; k++) begin
        load_ext(av[k]);
        ext_ctrl = cw(1'b0, 2'b01, 3'(op), 2'b00, 1'b0);
        data_in = bv[k];
        step();
        read_acc(op < 4 ? "R4 arithmetic op" : "R5 logic op",
                 model(av[k], bv[k], 3'(op), 2'b00));
      end
    end
  endtask

  task automatic t_shift();
    for (int s = 0; s < 4; s++) begin
      load_ext(8'hB5);
      ext_ctrl = cw(1'b0, 2'b01, 3'd0, 2'(s), 1'b0);
      step();
      read_acc("R6 shift op", model(8'hB5, 8'h00, 3'd0, 2'(s)));
    end
    load_ext(8'h81);
    ext_ctrl = cw(1'b0, 2'b01, 3'd1, 2'b01, 1'b0);
    data_in = 8'h01;
    step();
    read_acc("R6 add then left", 8'h04);
  endtask

  task automatic t_acc_ops();
    load_ext(8'h3C);
    ext_ctrl = cw(1'b1, 2'b11, 3'd0, 2'b00, 1'b0);
    data_in = 8'hEE;
    step();
    read_acc("R2 code 11 holds", 8'h3C);
    ext_ctrl = cw(1'b1, 2'b00, 3'd0, 2'b00, 1'b0);
    step();
    read_acc("R2 code 00 holds", 8'h3C);
    ext_ctrl = cw(1'b1, 2'b10, 3'd0, 2'b00, 1'b0);
    step();
    read_acc("R2 clear", 8'h00);
  endtask

  task automatic t_gate();
    load_ext(8'hA7);
    ext_ctrl = cw(1'b0, 2'b00, 3'd0, 2'b00, 1'b0);
    #1;
    check("R7 gated off", data_out, 0);
    check("R7 out_en low", out_en, 0);
    ext_ctrl_en = 1'b0;
    data_in = 8'h11;
    step();
    check("R11 idle no ext out_en", out_en, 0);
    read_acc("R11 idle holds", 8'hA7);
  endtask

  task automatic t_sum();
    logic [W-1:0] sum = '0;
    load_ext(8'h99);
    ext_ctrl_en = 1'b0;
    start = 1'b1;
    step();
    start = 1'b0;
    check("R8 busy after start", busy, 1);
    step();
    for (int i = 0; i < N; i++) begin
      if (i % 7 == 3) begin
        // R10: gap cycle with hostile inputs
        sample_valid = 1'b0; data_in = 8'hFF; start = 1'b1;
        ext_ctrl_en = 1'b1; ext_ctrl = cw(1'b0, 2'b10, 3'd0, 2'b00, 1'b1);
        #1;
        check("R10 ext ignored while busy", out_en, 0);
        step();
        start = 1'b0; ext_ctrl_en = 1'b0;
      end
      sample_valid = 1'b1;
      data_in = W'((i * 37 + 11) & 8'hFF);
      sum = sum + data_in;
      step();
      if (i < N - 1) check("R9 no early done", done, 0);
    end
    sample_valid = 1'b0;
    #1;
    check("R9 done high", done, 1);
    check("R9 out_en with done", out_en, 1);
    check("R8 wrapped sum", data_out, sum);
    step();
    check("R9 done one cycle", done, 0);
    check("R9 idle again", busy, 0);
    read_acc("R8 sum retained", sum);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_load_select();
    t_alu_ops();
    t_shift();
    t_acc_ops();
    t_gate();
    t_sum();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule